// File: doc/BRIEF.md
# Write-Only I2C Control Register Slave

This block is a write-only I2C target. It holds a small control register file and drives its fields straight out as configuration signals for a filter and gain stage. A fast system clock samples the bus lines through two-flop synchronisers. Bus state changes (START, STOP, clock edges) are found from the synchronised samples, and the acknowledge is returned by asserting an open-drain pull-low enable for SDA.

A host writes by sending the device address with the write direction, then a register pointer byte, then one or more data bytes. The pointer steps forward after every stored byte, so one transfer can fill consecutive registers. Once the pointer has passed the last register, the block refuses further data with a NACK and stores nothing more until a new transfer begins. Three devices can share one bus, because a three-level select input picks one of three adjacent addresses.

Top module: `i2c_wo_regslave`

## Requirements
- R1: The 7-bit device address is 0x48 when addrSel is 2'b00, 0x49 when addrSel is 2'b01, and 0x4A when addrSel is 2'b10 or 2'b11 (the floating level).
- R2: After each received byte that is accepted, the block asserts sdaPullLow while SCL is low and holds it through the whole ninth clock. It releases the line after the falling edge of SCL that ends that clock.
- R3: The register pointer is loaded from the byte that follows the address. It advances by one after every stored data byte, so bytes in one transfer land in consecutive registers.
- R4: A data byte that arrives while the pointer is above 0x03 is not stored and gets no acknowledge. No later byte in that transfer is stored or acknowledged.
- R5: An address byte with the R/W bit (bit 0) set to 1 is not acknowledged, and the transfer stores nothing.
- R6: Field map. Register 0 drives cutoffCode[7:0]. Register 1 bits 7..2 drive inputType[5:0] and bit 1 drives bypassEn. Register 2 bit 7 drives powerDown, bit 6 drives halfCutoff, and bits 5..0 drive gainMain. Register 3 bits 5..0 drive gainAux.
- R7: After reset, every register is 0x00, and so is every output field derived from them.
- R8: A register changes as a whole byte, at the falling SCL edge that begins its acknowledge clock. The new value is visible on the outputs before that acknowledge clock ends.
- R9: A repeated START discards any partly received byte and restarts address reception.
- R10: An address that does not match gets no acknowledge. The block then ignores all bus activity until the next START or STOP.
- R11: A pointer byte above 0x03 is still acknowledged, but the data bytes after it are refused.
- R12: A STOP in the middle of a byte discards the partial byte and leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrSel | input | 2 | Address select level: 00 low, 01 high, 1x floating |
| sdaPullLow | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| cutoffCode | output | 8 | Filter cutoff code |
| inputType | output | 6 | Input coupling selection bits |
| bypassEn | output | 1 | Filter bypass flag |
| powerDown | output | 1 | Power-down flag |
| halfCutoff | output | 1 | Halved cutoff flag for the secondary channels |
| gainMain | output | 6 | Gain code for the primary channel group |
| gainAux | output | 6 | Gain code for the secondary channel group |

## Verification
The hardest conditions to reach from the pins are bus events that cut a byte short: a repeated START or a STOP after only a few bits of a data byte. The bench also has to show that a byte after the first refusal stays unstored even though the host keeps clocking. Directed sequences stop a byte after four bits and then issue a START or STOP. They also push the pointer from register 2 across the end of the file, and keep sending bytes after a NACK and after a wrong address. Random transfers with a fixed seed mix the addresses, direction bits, start pointers and lengths. A bench model tracks the expected acknowledges and register contents for each of them.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_DATA,
    PH_ACK_ADDR,
    PH_ACK_SUB,
    PH_ACK_DATA
  } phase_t;

  typedef struct packed {
    logic              loadSub;
    logic              writeData;
    logic [BYTE_W-1:0] rxByte;
  } strobe_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] devAddr,
  input  logic       inRange,
  output strobe_t    strobe,
  output logic       sdaPullLow
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic sclS, sdaS, sclQ, sdaQ;
  logic sclRise, sclFall, startDet, stopDet;
  phase_t phase;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic ackDrive;
  logic byteFull;

  i2cw_sync #(.STAGES(SYNC_STAGES)) uSyncScl (.clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  i2cw_sync #(.STAGES(SYNC_STAGES)) uSyncSda (.clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign byteFull = (bitCnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackDrive <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.loadSub   <= 1'b0;
      strobe.writeData <= 1'b0;
      if (startDet) begin
        phase    <= PH_ADDR;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
      end else if (stopDet) begin
        phase    <= PH_IDLE;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
      end else begin
        unique case (phase)
          PH_ADDR, PH_SUB, PH_DATA: begin
            if (sclRise && !byteFull) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && byteFull) begin
              strobe.rxByte <= shiftReg;
              if (phase == PH_ADDR) begin
                if (shiftReg[7:1] == devAddr && !shiftReg[0]) begin
                  ackDrive <= 1'b1;
                  phase    <= PH_ACK_ADDR;
                end else begin
                  phase <= PH_IDLE;
                end
              end else if (phase == PH_SUB) begin
                ackDrive       <= 1'b1;
                strobe.loadSub <= 1'b1;
                phase          <= PH_ACK_SUB;
              end else if (inRange) begin
                ackDrive         <= 1'b1;
                strobe.writeData <= 1'b1;
                phase            <= PH_ACK_DATA;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          PH_ACK_ADDR, PH_ACK_SUB, PH_ACK_DATA: begin
            if (sclFall) begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              phase    <= (phase == PH_ACK_ADDR) ? PH_SUB : PH_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaPullLow = ackDrive;

  AST_ACK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclS); // R2
  AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow && sclS && !startDet && !stopDet) |=> sdaPullLow); // R2
  AST_READ_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ADDR && sclFall && byteFull && shiftReg[0]) |=> !sdaPullLow); // R5
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !startDet) |=> !strobe.writeData && !strobe.loadSub); // R10
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
#(
  parameter int unsigned REG_COUNT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  output logic       inRange,
  output logic [7:0] cutoffCode,
  output logic [5:0] inputType,
  output logic       bypassEn,
  output logic       powerDown,
  output logic       halfCutoff,
  output logic [5:0] gainMain,
  output logic [5:0] gainAux
);
  localparam int unsigned IDX_W = $clog2(REG_COUNT);

  logic [BYTE_W-1:0] regFile [REG_COUNT];
  logic [BYTE_W-1:0] ptr;
  logic [REG_COUNT*BYTE_W-1:0] regsFlat;

  assign inRange = (ptr < BYTE_W'(REG_COUNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else begin
      if (strobe.loadSub) begin
        ptr <= strobe.rxByte;
      end else if (strobe.writeData && inRange) begin
        ptr <= ptr + 1'b1;
        for (int i = 0; i < REG_COUNT; i++)
          if (ptr[IDX_W-1:0] == IDX_W'(i)) regFile[i] <= strobe.rxByte;
      end
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gFlat
    assign regsFlat[g*BYTE_W +: BYTE_W] = regFile[g];
  end

  assign cutoffCode = regFile[0];
  assign inputType  = regFile[1][7:2];
  assign bypassEn   = regFile[1][1];
  assign powerDown  = regFile[2][7];
  assign halfCutoff = regFile[2][6];
  assign gainMain   = regFile[2][5:0];
  assign gainAux    = regFile[3][5:0];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeData && inRange) |=> ptr == $past(ptr) + 8'd1); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSub |=> ptr == $past(strobe.rxByte)); // R11
  AST_NO_STORE_PAST_END: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.writeData && !inRange) |=> $stable(regsFlat)); // R4
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeData |=> $stable(regsFlat)); // R8
endmodule

// File: rtl/i2c_wo_regslave.sv
module i2c_wo_regslave
  import i2cw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_COUNT   = 4,
  parameter logic [6:0]  ADDR_BASE   = 7'h48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrSel,
  output logic       sdaPullLow,
  output logic [7:0] cutoffCode,
  output logic [5:0] inputType,
  output logic       bypassEn,
  output logic       powerDown,
  output logic       halfCutoff,
  output logic [5:0] gainMain,
  output logic [5:0] gainAux
);
  logic [6:0] devAddr;
  logic       inRange;
  strobe_t    strobe;

  always_comb begin
    unique case (addrSel)
      2'b00:   devAddr = ADDR_BASE;
      2'b01:   devAddr = ADDR_BASE + 7'd1;
      default: devAddr = ADDR_BASE + 7'd2;
    endcase
  end

  i2cw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devAddr(devAddr), .inRange(inRange), .strobe(strobe), .sdaPullLow(sdaPullLow)
  );

  i2cw_regs #(.REG_COUNT(REG_COUNT)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inRange(inRange),
    .cutoffCode(cutoffCode), .inputType(inputType), .bypassEn(bypassEn),
    .powerDown(powerDown), .halfCutoff(halfCutoff), .gainMain(gainMain), .gainAux(gainAux)
  );
endmodule

// File: tb/tb_i2c_wo_regslave.sv
module tb_i2c_wo_regslave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] addrSel = 2'b00;
  logic sdaPullLow, bypassEn, powerDown, halfCutoff;
  logic [7:0] cutoffCode;
  logic [5:0] inputType, gainMain, gainAux;
  logic sdaBus;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expReg [4];
  logic [7:0] dat [8];

  always #4 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  i2c_wo_regslave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrSel(addrSel),
    .sdaPullLow(sdaPullLow), .cutoffCode(cutoffCode), .inputType(inputType),
    .bypassEn(bypassEn), .powerDown(powerDown), .halfCutoff(halfCutoff),
    .gainMain(gainMain), .gainAux(gainAux)
  );

  function automatic logic [6:0] addrOf(input logic [1:0] s);
    return (s == 2'b00) ? 7'h48 : (s == 2'b01) ? 7'h49 : 7'h4A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic checkOutputs(input string req);
    chk(cutoffCode == expReg[0], req, "cutoffCode", cutoffCode, expReg[0]);
    chk(inputType == expReg[1][7:2], req, "inputType", inputType, expReg[1][7:2]);
    chk(bypassEn == expReg[1][1], req, "bypassEn", bypassEn, expReg[1][1]);
    chk(powerDown == expReg[2][7], req, "powerDown", powerDown, expReg[2][7]);
    chk(halfCutoff == expReg[2][6], req, "halfCutoff", halfCutoff, expReg[2][6]);
    chk(gainMain == expReg[2][5:0], req, "gainMain", gainMain, expReg[2][5:0]);
    chk(gainAux == expReg[3][5:0], req, "gainAux", gainAux, expReg[3][5:0]);
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(); sclM = 1; waitQ(); waitQ(); sclM = 0; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) sendBit(b[i]);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1; waitQ(); sclM = 1; waitQ();
    acked = sdaPullLow;
    waitQ(); sclM = 0; waitQ();
  endtask

  task automatic transfer(input logic [6:0] a7, input logic rw, input logic [7:0] sub,
                          input int n, input string req);
    bit acked, expA, refused;
    int ptrE;
    startCond();
    sendByte({a7, rw}, acked);
    expA = (a7 == addrOf(addrSel)) && !rw;
    chk(acked == expA, req, "address ack", acked, expA);
    sendByte(sub, acked);
    chk(acked == expA, req, "pointer ack", acked, expA);
    refused = !expA;
    ptrE = sub;
    for (int k = 0; k < n; k++) begin
      bit expD;
      sendByte(dat[k], acked);
      expD = !refused && ptrE < 4;
      chk(acked == expD, req, "data ack", acked, expD);
      if (expD) begin
        expReg[ptrE] = dat[k];
        ptrE++;
        checkOutputs({req, " R8"});
      end else refused = 1;
    end
    stopCond();
    checkOutputs(req);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acked;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) expReg[i] = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    checkOutputs("R7");
    chk(sdaPullLow == 1'b0, "R7", "sdaPullLow", sdaPullLow, 0);

    // R3 R6: fill all four registers in one transfer
    dat[0] = 8'hA5; dat[1] = 8'b1011_0110; dat[2] = 8'b1001_0111; dat[3] = 8'h2C;
    transfer(7'h48, 1'b0, 8'h00, 4, "R3 R6");
    chk(bypassEn == 1'b1 && inputType == 6'b101101, "R6", "reg1 fields", {inputType, bypassEn}, 7'b1011011);
    chk(powerDown && !halfCutoff && gainMain == 6'h17, "R6", "reg2 fields", {powerDown, halfCutoff, gainMain}, 8'h97);

    // R1: high level select, old address must be refused
    addrSel = 2'b01;
    dat[0] = 8'h11;
    transfer(7'h48, 1'b0, 8'h00, 1, "R1 R10");
    transfer(7'h49, 1'b0, 8'h00, 1, "R1");
    addrSel = 2'b10;
    dat[0] = 8'h3E;
    transfer(7'h4A, 1'b0, 8'h03, 1, "R1");
    addrSel = 2'b11;
    dat[0] = 8'h21;
    transfer(7'h4A, 1'b0, 8'h03, 1, "R1");
    addrSel = 2'b00;

    // R5: read direction refused
    dat[0] = 8'hFF;
    transfer(7'h48, 1'b1, 8'h00, 1, "R5");

    // R4: run past the end from register 2
    dat[0] = 8'h45; dat[1] = 8'h0A; dat[2] = 8'h99; dat[3] = 8'h77;
    transfer(7'h48, 1'b0, 8'h02, 4, "R4");

    // R11: out-of-range pointer acknowledged, data refused
    dat[0] = 8'h5A; dat[1] = 8'h00;
    transfer(7'h48, 1'b0, 8'h10, 2, "R11");

    // R9: repeated START after half a data byte
    startCond();
    sendByte({7'h48, 1'b0}, acked);
    sendByte(8'h01, acked);
    sendBits(8'hFF, 4);
    dat[0] = 8'h0F;
    transfer(7'h48, 1'b0, 8'h03, 1, "R9");
    chk(inputType == expReg[1][7:2], "R9", "partial byte dropped", inputType, expReg[1][7:2]);

    // R12: STOP after half a data byte
    startCond();
    sendByte({7'h48, 1'b0}, acked);
    sendByte(8'h00, acked);
    sendBits(8'h00, 4);
    stopCond();
    checkOutputs("R12");

    // R10: mismatch, then a byte equal to our address without a START
    startCond();
    sendByte({7'h4B, 1'b0}, acked);
    chk(acked == 0, "R10", "mismatch ack", acked, 0);
    sendByte({7'h48, 1'b0}, acked);
    chk(acked == 0, "R10", "ignored addr ack", acked, 0);
    sendByte(8'h00, acked);
    chk(acked == 0, "R10", "ignored ptr ack", acked, 0);
    stopCond();
    checkOutputs("R10");

    // random transfers
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a7;
      logic rw;
      int n;
      addrSel = 2'($urandom_range(0, 3));
      a7 = 7'h48 + 7'($urandom_range(0, 3));
      rw = ($urandom_range(0, 9) == 0);
      n = $urandom_range(1, 5);
      for (int k = 0; k < 8; k++) dat[k] = 8'($urandom);
      transfer(a7, rw, 8'($urandom_range(0, 5)), n, "R2 R3 R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule